// File: doc/BRIEF.md
# Peripheral Clock Gate Bank

This block holds one clock-enable bit for each of up to 64 peripherals and drives those bits straight out as gate-enable signals for the clock gating cells nearby. A peripheral is picked by its ID. IDs 0 to 31 live in the low bank and IDs 32 to 63 in the high bank. Within a bank the bit index is the ID modulo 32.

Software never writes an enable bit directly. Each bank has three word registers:
- a turn-on register, where any 1 bit switches that peripheral on;
- a turn-off register, where any 1 bit switches it off;
- a read-only state register.

Because of this, a driver can change one peripheral without a read-modify-write race against another driver. The two lowest IDs are permanently on. Writes cannot gate them.

Register addressing is by word. `addr[3:2]` selects the bank: 0 is the low bank and 1 is the high bank. `addr[1:0]` selects the register: 0 is turn-on, 1 is turn-off, 2 is state and 3 is reserved. Read data is combinational and valid in the same cycle as `rdEn`.

Top module: `clk_gate_bank`

## Requirements
- R1: A write to a turn-on register (`addr[1:0]`=0) sets every enable bit whose data bit is 1. The new value is visible on `gateEn` right after the clock edge that samples the write.
- R2: A write to a turn-off register (`addr[1:0]`=1) clears every enable bit whose data bit is 1, with the same one-edge latency.
- R3: Data bits that are 0 in a turn-on or turn-off write leave their enables unchanged. Cycles without `wrEn` change nothing.
- R4: A read of a state register (`addr[1:0]`=2) returns the current enable of each peripheral in that bank. Bit i of bank b is ID 32*b+i.
- R5: IDs 0 and 1 always drive `gateEn` high and read back as 1. Turn-off writes do not affect them.
- R6: The high bank (`addr[3:2]`=1) acts on IDs 32 to 63 and leaves the low bank untouched, and the low bank likewise leaves the high bank untouched.
- R7: While `rstN` is low, and after reset, every ID at 2 or above is disabled.
- R8: Reads of turn-on, turn-off, reserved or unmapped addresses (`addr[3:2]` ≥ 2) return zero. Writes to reserved or unmapped addresses change no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 4 | Word address: bank in [3:2], register in [1:0] |
| wrData | input | 32 | Write data, one bit per peripheral of the bank |
| rdData | output | 32 | Read data, zero unless a state register is read |
| gateEn | output | 64 | Clock enable per peripheral ID |

## Verification
The hardest case to reach from the ports is a write whose mask includes the two permanently-on IDs while neighbouring bits in the same word change. The bench aims turn-off writes with all ones at the low bank on purpose, and then mixes in random writes over every address including unmapped ones. A behavioural 64-bit model is compared against `gateEn` on every cycle, so any leak into the fixed bits or across banks shows up at once. Reads of every address are checked against the same model.

// File: rtl/clk_gate_bank_pkg.sv
package clk_gate_bank_pkg;
  localparam int REG_SEL_W = 2;
  localparam int BANK_IDX_W = 4;

  typedef enum logic [REG_SEL_W-1:0] {
    REG_ON   = 2'd0,
    REG_OFF  = 2'd1,
    REG_STAT = 2'd2,
    REG_RSVD = 2'd3
  } regSel_e;

  typedef struct packed {
    logic                  onStb;
    logic                  offStb;
    logic                  statStb;
    logic [BANK_IDX_W-1:0] bankIdx;
  } strobe_t;
endpackage

// File: rtl/clk_gate_bank_ctrl.sv
module clk_gate_bank_ctrl
  import clk_gate_bank_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_BANKS = 2
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe
);
  localparam int BANK_W = ADDR_W - REG_SEL_W;

  logic [BANK_W-1:0] bankField;
  regSel_e           regField;
  logic              inRange;

  always_comb begin
    bankField      = addr[ADDR_W-1:REG_SEL_W];
    regField       = regSel_e'(addr[REG_SEL_W-1:0]);
    inRange        = (int'(bankField) < NUM_BANKS);
    strobe.onStb   = wrEn && inRange && (regField == REG_ON);
    strobe.offStb  = wrEn && inRange && (regField == REG_OFF);
    strobe.statStb = rdEn && inRange && (regField == REG_STAT);
    strobe.bankIdx = BANK_IDX_W'(bankField);
  end
endmodule

// File: rtl/clk_gate_bank_dp.sv
module clk_gate_bank_dp
  import clk_gate_bank_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int DATA_W     = 32,
  parameter int ALWAYS_ON  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_PERIPH-1:0] gateEn
);
  localparam int NUM_BANKS = (NUM_PERIPH + DATA_W - 1) / DATA_W;
  localparam int PAD_W     = NUM_BANKS * DATA_W;

  logic [PAD_W-1:0] enPad;

  function automatic logic [DATA_W-1:0] fixedMask(input int b);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((b * DATA_W + i) < ALWAYS_ON);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] validMask(input int b);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((b * DATA_W + i) < NUM_PERIPH);
    return m;
  endfunction

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [DATA_W-1:0] FIXED = fixedMask(b);
    localparam logic [DATA_W-1:0] VALID = validMask(b);

    logic              bankHit;
    logic [DATA_W-1:0] onVec;
    logic [DATA_W-1:0] offVec;
    logic [DATA_W-1:0] bankQ;

    always_comb begin
      bankHit = (int'(strobe.bankIdx) == b);
      onVec   = (bankHit && strobe.onStb)  ? wrData : '0;
      offVec  = (bankHit && strobe.offStb) ? wrData : '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bankQ <= '0;
      else       bankQ <= ((bankQ | onVec) & ~offVec) & VALID & ~FIXED;
    end

    assign enPad[b*DATA_W +: DATA_W] = (bankQ | FIXED) & VALID;
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobe.statStb && (int'(strobe.bankIdx) == b)) rdData = enPad[b*DATA_W +: DATA_W];
    end
  end

  assign gateEn = enPad[NUM_PERIPH-1:0];
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
  import clk_gate_bank_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int ALWAYS_ON  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_PERIPH-1:0] gateEn
);
  localparam int NUM_BANKS = (NUM_PERIPH + DATA_W - 1) / DATA_W;

  strobe_t strobe;

  clk_gate_bank_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS)
  ) i_ctrl (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .strobe(strobe)
  );

  clk_gate_bank_dp #(
    .NUM_PERIPH(NUM_PERIPH),
    .DATA_W    (DATA_W),
    .ALWAYS_ON (ALWAYS_ON)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .rdData(rdData),
    .gateEn(gateEn)
  );
endmodule

// File: rtl/clk_gate_bank_chk.sv
module clk_gate_bank_chk #(
  parameter int NUM_PERIPH = 64,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int ALWAYS_ON  = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [ADDR_W-1:0]     addr,
  input logic [DATA_W-1:0]     wrData,
  input logic [DATA_W-1:0]     rdData,
  input logic [NUM_PERIPH-1:0] gateEn
);
  localparam logic [ADDR_W-1:0] A_ON_LO   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OFF_LO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ON_HI   = ADDR_W'(4);
  localparam logic [DATA_W-1:0] FIXED_LO  = DATA_W'((64'd1 << ALWAYS_ON) - 64'd1);

  AST_ON_SETS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_ON_LO) |=> ((gateEn[DATA_W-1:0] & $past(wrData)) == $past(wrData))); // R1

  AST_OFF_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_OFF_LO) |=> ((gateEn[DATA_W-1:0] & $past(wrData) & ~FIXED_LO) == '0)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(gateEn)); // R3

  AST_STATE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == A_STAT_LO) |-> (rdData == gateEn[DATA_W-1:0])); // R4

  AST_FIXED_ON: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn[ALWAYS_ON-1:0] & FIXED_LO[ALWAYS_ON-1:0]) == FIXED_LO[ALWAYS_ON-1:0]); // R5

  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_ON_HI) |=> $stable(gateEn[DATA_W-1:0])); // R6

  AST_WRITE_ONLY_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[1:0] != 2'd2) |-> (rdData == '0)); // R8
endmodule

bind clk_gate_bank clk_gate_bank_chk #(
  .NUM_PERIPH(NUM_PERIPH),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .ALWAYS_ON (ALWAYS_ON)
) i_chk (.*);

// File: tb/test_clk_gate_bank.sv
`timescale 1ns/1ps
module test_clk_gate_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] gateEn;

  logic [63:0] model;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit cmpOn = 1'b0;

  always #2.5 clk = ~clk;

  clk_gate_bank i_clk_gate_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .gateEn(gateEn)
  );

  // Behavioural reference: 64 enables, IDs 0 and 1 pinned on.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) model <= 64'h3;
    else if (wrEn) begin
      logic [63:0] nxt;
      int bank;
      nxt = model;
      bank = int'(addr[3:2]);
      if (bank < 2) begin
        for (int k = 0; k < 32; k++) begin
          if (wrData[k] && addr[1:0] == 2'd0) nxt[bank*32 + k] = 1'b1;
          if (wrData[k] && addr[1:0] == 2'd1) nxt[bank*32 + k] = 1'b0;
        end
      end
      nxt[1:0] = 2'b11;
      model <= nxt;
    end
  end

  function automatic logic [31:0] expRead(input logic [3:0] a);
    if (a[3:2] < 2'd2 && a[1:0] == 2'd2) return model[int'(a[3:2])*32 +: 32];
    return 32'h0;
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every cycle: outputs against the reference (R1 R2 R3 R5 R6).
  always @(negedge clk) begin
    if (cmpOn) check64("R1/R2/R3/R6 per-cycle gateEn", gateEn, model);
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1;
    check64(tag, {32'h0, rdData}, {32'h0, exp});
    check64({tag, " model"}, {32'h0, rdData}, {32'h0, expRead(a)});
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    check64("R7 gateEn during reset", gateEn, 64'h3);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;
    check64("R7 after reset", gateEn, 64'h3);
    rd("R4 R5 low state after reset", 4'h2, 32'h3);
    rd("R4 high state after reset", 4'h6, 32'h0);

    wr(4'h0, 32'h0000_00F0);
    check64("R1 low turn-on", gateEn, 64'h0000_0000_0000_00F3);
    wr(4'h0, 32'h0);
    check64("R3 zero turn-on mask", gateEn, 64'h0000_0000_0000_00F3);
    wr(4'h1, 32'h0000_0030);
    check64("R2 low turn-off", gateEn, 64'h0000_0000_0000_00C3);
    wr(4'h1, 32'h0);
    check64("R3 zero turn-off mask", gateEn, 64'h0000_0000_0000_00C3);
    wr(4'h1, 32'hFFFF_FFFF);
    check64("R5 fixed IDs survive turn-off", gateEn, 64'h3);
    wr(4'h0, 32'hFFFF_FFFF);
    check64("R1 all low on", gateEn, 64'h0000_0000_FFFF_FFFF);
    wr(4'h4, 32'h8000_0001);
    check64("R6 high turn-on", gateEn, 64'h8000_0001_FFFF_FFFF);
    wr(4'h5, 32'h0000_0003);
    check64("R6 high turn-off bits 0,1 not fixed", gateEn, 64'h8000_0000_FFFF_FFFF);
    rd("R4 high state", 4'h6, 32'h8000_0000);
    wr(4'h1, 32'hFFFF_0000);
    check64("R6 low turn-off leaves high", gateEn, 64'h8000_0000_0000_FFFF);
    rd("R4 low state", 4'h2, 32'h0000_FFFF);

    rd("R8 read turn-on low", 4'h0, 32'h0);
    rd("R8 read turn-off low", 4'h1, 32'h0);
    rd("R8 read reserved", 4'h3, 32'h0);
    rd("R8 read turn-on high", 4'h4, 32'h0);
    rd("R8 read unmapped bank", 4'hA, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    check64("R8 unmapped write ignored", gateEn, 64'h8000_0000_0000_FFFF);
    wr(4'h3, 32'hFFFF_FFFF);
    check64("R8 reserved write ignored", gateEn, 64'h8000_0000_0000_FFFF);
    repeat (5) @(negedge clk);
    check64("R3 idle holds", gateEn, 64'h8000_0000_0000_FFFF);

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [3:0] ra;
        ra = 4'($urandom_range(0, 15));
        rd("R4/R8 random read", ra, expRead(ra));
      end else begin
        wr(4'($urandom_range(0, 15)), $urandom());
      end
    end

    rstN = 1'b0;
    #1;
    check64("R7 re-reset", gateEn, 64'h3);
    cmpOn = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule